// File: doc/BRIEF.md
# Write-Back Data Cache Without Write Allocation

This block is a small fully associative data cache that sits in the memory stage of an in-order pipeline. The stage offers one access at a time: an address, a store flag, a data word and a four-bit byte mask. A hit finishes in a single cycle and never lowers throughput. Any miss raises a stall output that holds the pipeline for a fixed penalty while a single memory port does the required transfer.

Loads that miss fetch the whole 16-byte line and install it clean. Stores that hit merge their bytes into the cached line and mark it dirty; memory is not touched until that line is evicted. Stores that miss go straight to memory as one masked word and leave the cache untouched. When a load miss must evict a dirty line, the old line is first written back in full. This write-back adds to the stall, on top of the fixed penalty.

Victims are taken from free entries first. Once every entry is in use, a rotating pointer picks them. The memory side is a plain request/acknowledge port with one transfer outstanding.

Top module: `wbna_dcache`

## Requirements
- R1: Addresses split as tag = bits [31:4], word = bits [3:2], byte = bits [1:0]. A line may sit in any entry and at most one entry matches a tag. A load hit returns the cached word selected by bits [3:2].
- R2: An access that hits and is accepted in cycle C drives resp_valid high in cycle C+1. stall stays low throughout, and mem_req is never raised.
- R3: An access that misses, when no dirty line needs evicting, is accepted in cycle C. stall is then high for PENALTY cycles (default 4, cycles C+1 to C+4), and resp_valid pulses in the cycle stall falls (C+5). The access thus occupies the stage for five cycles.
- R4: A load miss reads the line as four beats with mem_write low, at the line base plus 0, 4, 8 and 12. It installs the line clean and returns the requested word.
- R5: A store hit writes byte lane i (bits [8i+7:8i]) when bit i of req_be is set and marks the line dirty. It issues no memory write, and later loads return the merged word.
- R6: A store miss issues exactly one memory write, with mem_addr equal to the request address and the store data and mask. It allocates nothing, so a later load of that line misses. Its timing follows R3.
- R7: After reset every entry is invalid and stall, resp_valid and mem_req are low. The first access to each line is a miss.
- R8: The victim for a load miss is the lowest-numbered invalid entry. When all entries are valid, a round-robin pointer chooses instead. The pointer starts at entry 0 after reset and advances by one, wrapping, after each replacement of a valid line.
- R9: A dirty victim is first written to memory as four beats. Each beat uses mask 4'hF and the old line's base address plus 0, 4, 8, 12 in ascending order. All four happen before any fill read. With memory acknowledging in the cycle of each request, stall lasts 4 + PENALTY cycles and the response comes in C+9.
- R10: A clean victim is discarded without any memory write.
- R11: All request inputs are ignored while stall is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access offered this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte mask, bit i selects bits [8i+7:8i] |
| stall | output | 1 | Miss in progress; pipeline must hold |
| resp_valid | output | 1 | Access completed this cycle |
| resp_rdata | output | 32 | Load result, valid with resp_valid on loads |
| mem_req | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte mask |
| mem_ack | input | 1 | Memory accepts the current transfer |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack on reads |

## Verification
The properties assume that memory holds a request steady until it acknowledges, and that read data is valid in the acknowledge cycle. The stall-length checks assume memory is never faster than the cache can issue. The bench's memory model acknowledges every request in the cycle it appears, which is the fastest legal memory. This makes the predicted stall lengths exact: five cycles for a plain miss, nine for a dirty eviction. The bench offers new accesses only when stall is low and resp_valid has been seen, and the only traffic it drives during a stall is deliberate junk that the cache must ignore.

// File: rtl/wbna_pkg.sv
package wbna_pkg;
  localparam int LINE_WORDS = 4;
  localparam int WORD_SEL_W = 2;
  localparam int OFFSET_W   = 4;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_WMISS = 2'd3
  } miss_state_e;
endpackage

// File: rtl/wbna_tag_cam.sv
module wbna_tag_cam #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 28,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic [ENTRIES-1:0] match_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             install_en,
  input  logic [IDX_W-1:0] install_idx,
  input  logic [TAG_W-1:0] install_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] dirty_q, dirty_d;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == lookup_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
  assign hit = |match_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end
  assign free_any = ~&valid_q;

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (install_en) begin
      valid_d[install_idx] = 1'b1;
      dirty_d[install_idx] = 1'b0;
    end
    if (dirty_en) dirty_d[dirty_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) tag_q[install_idx] <= install_tag;
  end
endmodule

// File: rtl/wbna_victim.sv
module wbna_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             free_any,
  input  logic [IDX_W-1:0] free_idx,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (advance) ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign victim_idx = free_any ? free_idx : ptr_q;
endmodule

// File: rtl/wbna_line_store.sv
module wbna_line_store
  import wbna_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WORD_SEL_W-1:0] wr_word,
  input  logic [BE_W-1:0]       wr_be,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [WORD_SEL_W-1:0] rd_word,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int SLOTS = ENTRIES * LINE_WORDS;

  logic [DATA_W-1:0] word_q [SLOTS];
  logic [IDX_W+WORD_SEL_W-1:0] wr_slot, rd_slot;

  assign wr_slot = {wr_idx, wr_word};
  assign rd_slot = {rd_idx, rd_word};

  always_ff @(posedge clk) begin
    for (int b = 0; b < BE_W; b++) begin
      if (wr_en && wr_be[b]) word_q[wr_slot][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign rd_data = word_q[rd_slot];
endmodule

// File: rtl/wbna_miss_fsm.sv
module wbna_miss_fsm
  import wbna_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int PENALTY = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [BE_W-1:0]       req_be,
  input  logic                  hit,
  input  logic [IDX_W-1:0]      hit_idx,
  input  logic [IDX_W-1:0]      victim_idx,
  input  logic                  victim_valid,
  input  logic                  victim_dirty,
  input  logic [ADDR_W-OFFSET_W-1:0] victim_tag,
  input  logic [DATA_W-1:0]     st_rd_data,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  stall,
  output logic                  resp_valid,
  output logic [DATA_W-1:0]     resp_rdata,
  output logic                  mem_req,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [BE_W-1:0]       mem_be,
  output logic                  st_wr_en,
  output logic [IDX_W-1:0]      st_wr_idx,
  output logic [WORD_SEL_W-1:0] st_wr_word,
  output logic [BE_W-1:0]       st_wr_be,
  output logic [DATA_W-1:0]     st_wr_data,
  output logic [IDX_W-1:0]      st_rd_idx,
  output logic [WORD_SEL_W-1:0] st_rd_word,
  output logic                  install_en,
  output logic [IDX_W-1:0]      install_idx,
  output logic [ADDR_W-OFFSET_W-1:0] install_tag,
  output logic                  dirty_en,
  output logic [IDX_W-1:0]      dirty_idx,
  output logic                  rr_advance
);
  localparam int TAG_W = ADDR_W - OFFSET_W;
  localparam int CNT_W = $clog2(PENALTY + 1);
  localparam logic [CNT_W-1:0] PEN_LAST = CNT_W'(PENALTY - 1);
  localparam logic [WORD_SEL_W-1:0] BEAT_LAST = WORD_SEL_W'(LINE_WORDS - 1);

  miss_state_e             state_q, state_d;
  logic [WORD_SEL_W-1:0]   beat_q, beat_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    sent_q, sent_d;
  logic                    resp_valid_d;
  logic [DATA_W-1:0]       resp_rdata_q, resp_rdata_d;
  logic [ADDR_W-1:0]       addr_q;
  logic [DATA_W-1:0]       wdata_q;
  logic [BE_W-1:0]         be_q;
  logic [IDX_W-1:0]        vic_q;
  logic [TAG_W-1:0]        wb_tag_q;
  logic                    resp_valid_q;

  logic accept, hit_acc, miss_acc, pen_ok, beat_ack;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign hit_acc  = accept && hit;
  assign miss_acc = accept && !hit;
  assign pen_ok   = (cnt_q >= PEN_LAST);
  assign beat_ack = mem_req && mem_ack;

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    cnt_d        = cnt_q;
    sent_d       = sent_q;
    resp_valid_d = 1'b0;
    resp_rdata_d = resp_rdata_q;
    mem_req      = 1'b0;
    mem_write    = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    mem_be       = '0;
    st_wr_en     = 1'b0;
    st_wr_idx    = hit_idx;
    st_wr_word   = req_addr[OFFSET_W-1:2];
    st_wr_be     = req_be;
    st_wr_data   = req_wdata;
    st_rd_idx    = hit_idx;
    st_rd_word   = req_addr[OFFSET_W-1:2];
    install_en   = 1'b0;
    install_idx  = vic_q;
    install_tag  = addr_q[ADDR_W-1:OFFSET_W];
    dirty_en     = 1'b0;
    dirty_idx    = hit_idx;
    rr_advance   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hit_acc) begin
          resp_valid_d = 1'b1;
          if (req_write) begin
            st_wr_en = 1'b1;
            dirty_en = 1'b1;
          end else begin
            resp_rdata_d = st_rd_data;
          end
        end else if (miss_acc) begin
          beat_d = '0;
          cnt_d  = '0;
          sent_d = 1'b0;
          if (req_write) begin
            state_d = ST_WMISS;
          end else begin
            rr_advance = victim_valid;
            state_d    = (victim_valid && victim_dirty) ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_req    = 1'b1;
        mem_write  = 1'b1;
        mem_addr   = {wb_tag_q, beat_q, 2'b00};
        mem_wdata  = st_rd_data;
        mem_be     = '1;
        st_rd_idx  = vic_q;
        st_rd_word = beat_q;
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == BEAT_LAST) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req    = !sent_q;
        mem_addr   = {addr_q[ADDR_W-1:OFFSET_W], beat_q, 2'b00};
        st_wr_idx  = vic_q;
        st_wr_word = beat_q;
        st_wr_be   = '1;
        st_wr_data = mem_rdata;
        cnt_d      = pen_ok ? cnt_q : cnt_q + 1'b1;
        if (beat_ack) begin
          st_wr_en = 1'b1;
          beat_d   = beat_q + 1'b1;
          if (beat_q == addr_q[OFFSET_W-1:2]) resp_rdata_d = mem_rdata;
          if (beat_q == BEAT_LAST) sent_d = 1'b1;
        end
        if ((sent_q || (beat_ack && beat_q == BEAT_LAST)) && pen_ok) begin
          state_d      = ST_IDLE;
          install_en   = 1'b1;
          resp_valid_d = 1'b1;
        end
      end
      ST_WMISS: begin
        mem_req   = !sent_q;
        mem_write = 1'b1;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        mem_be    = be_q;
        cnt_d     = pen_ok ? cnt_q : cnt_q + 1'b1;
        if (beat_ack) sent_d = 1'b1;
        if ((sent_q || beat_ack) && pen_ok) begin
          state_d      = ST_IDLE;
          resp_valid_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      beat_q       <= '0;
      cnt_q        <= '0;
      sent_q       <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      state_q      <= state_d;
      beat_q       <= beat_d;
      cnt_q        <= cnt_d;
      sent_q       <= sent_d;
      resp_valid_q <= resp_valid_d;
      resp_rdata_q <= resp_rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_acc) begin
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      be_q     <= req_be;
      vic_q    <= victim_idx;
      wb_tag_q <= victim_tag;
    end
  end

  assign stall      = (state_q != ST_IDLE);
  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_rdata_q;
endmodule

// File: rtl/wbna_dcache.sv
module wbna_dcache
  import wbna_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PENALTY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_be,
  output logic        stall,
  output logic        resp_valid,
  output logic [31:0] resp_rdata,
  output logic        mem_req,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int ADDR_W = 32;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = ADDR_W - OFFSET_W;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [ENTRIES-1:0]    match_vec;
  logic                  hit_any, free_any, vic_valid, vic_dirty;
  logic [IDX_W-1:0]      hit_idx, free_idx, victim_idx;
  logic [TAG_W-1:0]      vic_tag, install_tag;
  logic                  install_en, dirty_en, rr_advance, st_wr_en;
  logic [IDX_W-1:0]      install_idx, dirty_idx, st_wr_idx, st_rd_idx;
  logic [WORD_SEL_W-1:0] st_wr_word, st_rd_word;
  logic [BE_W-1:0]       st_wr_be;
  logic [DATA_W-1:0]     st_wr_data, st_rd_data;

  wbna_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .rst_n(rst_core_n),
    .lookup_tag(req_addr[ADDR_W-1:OFFSET_W]),
    .match_vec(match_vec), .hit(hit_any), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx),
    .rd_idx(victim_idx), .rd_valid(vic_valid), .rd_dirty(vic_dirty), .rd_tag(vic_tag),
    .install_en(install_en), .install_idx(install_idx), .install_tag(install_tag),
    .dirty_en(dirty_en), .dirty_idx(dirty_idx)
  );

  wbna_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_core_n),
    .free_any(free_any), .free_idx(free_idx),
    .advance(rr_advance), .victim_idx(victim_idx)
  );

  wbna_line_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_word(st_wr_word),
    .wr_be(st_wr_be), .wr_data(st_wr_data),
    .rd_idx(st_rd_idx), .rd_word(st_rd_word), .rd_data(st_rd_data)
  );

  wbna_miss_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PENALTY(PENALTY)) u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be),
    .hit(hit_any), .hit_idx(hit_idx), .victim_idx(victim_idx),
    .victim_valid(vic_valid), .victim_dirty(vic_dirty), .victim_tag(vic_tag),
    .st_rd_data(st_rd_data), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .stall(stall), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_word(st_wr_word),
    .st_wr_be(st_wr_be), .st_wr_data(st_wr_data),
    .st_rd_idx(st_rd_idx), .st_rd_word(st_rd_word),
    .install_en(install_en), .install_idx(install_idx), .install_tag(install_tag),
    .dirty_en(dirty_en), .dirty_idx(dirty_idx), .rr_advance(rr_advance)
  );
endmodule

// File: rtl/wbna_dcache_chk.sv
module wbna_dcache_chk #(
  parameter int ENTRIES = 16,
  parameter int PENALTY = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               stall,
  input logic               resp_valid,
  input logic               mem_req,
  input logic               mem_write,
  input logic               mem_ack,
  input logic [31:0]        mem_addr,
  input logic               hit_any,
  input logic [ENTRIES-1:0] match_vec
);
  logic [15:0] stall_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stall_run_q <= '0;
    else if (!stall)     stall_run_q <= '0;
    else if (stall_run_q != 16'hFFFF) stall_run_q <= stall_run_q + 16'd1;
  end

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R1

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall && hit_any) |=> (resp_valid && !stall)); // R2

  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> !mem_req); // R2

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall && !hit_any) |=> stall); // R3

  AST_MIN_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (stall_run_q >= 16'(PENALTY))); // R3

  AST_RESP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> resp_valid); // R3

  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_write) |=> !(mem_req && mem_write)); // R9

  AST_MEM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4
endmodule

bind wbna_dcache wbna_dcache_chk #(.ENTRIES(ENTRIES), .PENALTY(PENALTY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .stall(stall),
  .resp_valid(resp_valid), .mem_req(mem_req), .mem_write(mem_write),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .hit_any(hit_any), .match_vec(match_vec)
);

// File: tb/wbna_dcache_test.sv
module wbna_dcache_test;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 16;
  localparam int PENALTY    = 4;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        stall, resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_write, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  wbna_dcache #(.ENTRIES(ENTRIES), .PENALTY(PENALTY)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .stall(stall), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] bmem   [1024];
  logic [31:0] golden [1024];
  logic [31:0] wr_log [8];
  int          wr_total = 0;

  assign mem_ack   = mem_req;
  assign mem_rdata = bmem[mem_addr[11:2]];

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_write && mem_ack) begin
      bmem[mem_addr[11:2]] <= merge(bmem[mem_addr[11:2]], mem_wdata, mem_be);
      wr_log[wr_total % 8] <= mem_addr;
      wr_total <= wr_total + 1;
    end
  end

  logic [27:0] r_tag   [ENTRIES];
  bit          r_val   [ENTRIES];
  bit          r_dirty [ENTRIES];
  int          r_ptr;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  function automatic int find_line(logic [27:0] t);
    for (int i = 0; i < ENTRIES; i++) if (r_val[i] && r_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(bit wr, logic [31:0] addr, logic [31:0] data, logic [3:0] be, bit junk);
    int h, v, lat, exp_lat, exp_wr, wr_before;
    logic [31:0] exp_wa;
    string lat_tag, wr_tag;
    h = find_line(addr[31:4]);
    exp_wa = 32'h0;
    if (h >= 0) begin
      exp_lat = 1; exp_wr = 0;
      lat_tag = wr ? "R5" : "R2";
      wr_tag  = wr ? "R5" : "R2";
      if (wr) r_dirty[h] = 1;
    end else if (wr) begin
      exp_lat = 5; exp_wr = 1; exp_wa = addr;
      lat_tag = "R6"; wr_tag = "R6";
    end else begin
      v = -1;
      for (int i = ENTRIES - 1; i >= 0; i--) if (!r_val[i]) v = i;
      if (v < 0) begin
        v = r_ptr;
        r_ptr = (r_ptr + 1) % ENTRIES;
        lat_tag = "R8";
      end else begin
        lat_tag = "R3";
      end
      if (r_val[v] && r_dirty[v]) begin
        exp_lat = 9; exp_wr = 4; exp_wa = {r_tag[v], 4'h0};
        wr_tag = "R9";
      end else begin
        exp_lat = 5; exp_wr = 0;
        wr_tag = r_val[v] ? "R10" : "R4";
      end
      r_tag[v] = addr[31:4]; r_val[v] = 1; r_dirty[v] = 0;
    end

    @(negedge clk);
    wr_before = wr_total;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data; req_be = be;
    @(negedge clk);
    lat = 1;
    while (1) begin
      if (resp_valid) begin
        req_valid = 1'b0;
        break;
      end
      if (junk) begin
        req_valid = 1'b1; req_write = 1'b1;
        req_addr  = 32'($urandom_range(0, 39) * 16 + $urandom_range(0, 3) * 4);
        req_wdata = $urandom; req_be = 4'hF;
      end else begin
        req_valid = 1'b0;
      end
      if (lat > 40) break;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;

    check(lat == exp_lat, lat_tag, 32'(lat), 32'(exp_lat));
    check((wr_total - wr_before) == exp_wr, wr_tag, 32'(wr_total - wr_before), 32'(exp_wr));
    if (exp_wr > 0)
      check(wr_log[wr_before % 8] == exp_wa, wr_tag, wr_log[wr_before % 8], exp_wa);
    if (exp_wr == 4)
      check(wr_log[(wr_before + 3) % 8] == exp_wa + 32'd12, "R9",
            wr_log[(wr_before + 3) % 8], exp_wa + 32'd12);
    if (!wr)
      check(resp_rdata == golden[addr[11:2]], (h >= 0) ? "R1" : "R4",
            resp_rdata, golden[addr[11:2]]);
    else
      golden[addr[11:2]] = merge(golden[addr[11:2]], data, be);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) begin
      bmem[i]   = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      golden[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      r_val[i] = 0; r_dirty[i] = 0; r_tag[i] = '0;
    end
    r_ptr = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7: quiet outputs after reset
    check(stall == 1'b0, "R7", 32'(stall), 32'd0);
    check(resp_valid == 1'b0, "R7", 32'(resp_valid), 32'd0);
    check(mem_req == 1'b0, "R7", 32'(mem_req), 32'd0);

    // R7: cold miss, then R2 hit on the same line
    do_access(1'b0, 32'h100, 32'h0, 4'h0, 1'b0);
    do_access(1'b0, 32'h104, 32'h0, 4'h0, 1'b0);
    // R5: masked store hit, then read back
    do_access(1'b1, 32'h108, 32'hA1B2C3D4, 4'b0101, 1'b0);
    do_access(1'b0, 32'h108, 32'h0, 4'h0, 1'b0);
    // R6: store miss with junk during its stall (R11), then load misses
    do_access(1'b1, 32'h800, 32'hDEADBEEF, 4'b1100, 1'b1);
    do_access(1'b0, 32'h800, 32'h0, 4'h0, 1'b0);
    // fill the remaining entries
    for (int k = 0; k < ENTRIES - 2; k++)
      do_access(1'b0, 32'h300 + 32'(k * 16), 32'h0, 4'h0, 1'b0);
    // R8 and R9: pointer at entry 0, which is dirty
    do_access(1'b0, 32'hA00, 32'h0, 4'h0, 1'b0);
    // R10: next victim is clean
    do_access(1'b0, 32'hA10, 32'h0, 4'h0, 1'b0);
    // R9: data written back is seen on reload
    do_access(1'b0, 32'h108, 32'h0, 4'h0, 1'b1);
    // R11: junk stores issued during the stall left nothing behind
    for (int w = 0; w < 40; w++)
      do_access(1'b0, 32'(w * 16), 32'h0, 4'h0, 1'b0);

    for (int n = 0; n < 700; n++) begin
      bit          wr;
      logic [31:0] a;
      wr = ($urandom_range(0, 9) < 4);
      a  = 32'($urandom_range(0, 39) * 16 + $urandom_range(0, 3) * 4);
      do_access(wr, a, $urandom, 4'($urandom_range(1, 15)), (n % 3) == 0);
    end
    for (int w = 0; w < 160; w++)
      do_access(1'b0, 32'(w * 4), 32'h0, 4'h0, 1'b0);

    finish_run();
  end
endmodule